// File: doc/BRIEF.md
# Register-Driven SPI Master

This block is an SPI bus master that software drives through a small word-addressed register port. Software sets up a transfer in a fixed order. It picks the clock mode, bit order and SCLK divider. It loads a transmit word count and a receive word count. It puts bytes into a 16-entry transmit queue and sets the run bit. The shift engine then moves one byte per SPI word. It pulls each byte from the transmit queue and pushes each received byte into a 16-entry receive queue. Once both counts reach zero it goes idle, and software collects the received bytes through a read register.

No side of the block uses a handshake. The register port has no back-pressure: every write is taken in the cycle it appears. A write to a full transmit queue is thrown away. A read of an empty receive queue returns zero. Back-pressure acts inside the block instead. The engine waits with SCLK at its idle level if it needs a transmit byte and the queue is empty. It also waits if it must store a received byte and the receive queue is full. Chip select is never automatic: it follows a bit that software holds.

Between two words SCLK rests at its idle level for at least one system clock. Inside a word, each SCLK period lasts exactly the divider value in system clocks. The first half-period lasts `div/2` clocks, rounded down.

Top module: `spim_ctrl`

## Requirements
- R1: After reset, spi_cs_n is 1 and spi_sclk is 0. The divider reads 4. The status register reads 0. The FIFO level register (0x10C) reads 0x0010_0000, which means both levels are 0 and only the RX-empty bit 20 is set.
- R2: A write to 0x010 puts bits 7:0 into the TX queue. The TX level shows in bits 15:8 of 0x10C, and bit 4 is set when the level reaches 16. A write made while the TX queue is full is dropped.
- R3: A read of 0x020 removes the oldest RX byte. The byte appears in bus_rdata bits 7:0 in the cycle after the read strobe, in arrival order. If the RX queue is empty, the read returns 0. The RX level shows in bits 31:24 of 0x10C.
- R4: A write to the control register (0x000) with bit 2 set empties the TX queue. With bit 3 set it empties the RX queue. In both cases the level reads 0 afterwards.
- R5: A write to the divider register (0x030) is clamped to the range 2..0x7FF. Values below 2 store 2, and values above 0x7FF store 0x7FF.
- R6: Inside a word, SCLK sampling edges are exactly `div` system clocks apart. SCLK rests at the CPOL level (bit 2 of config register 0x004) whenever no word is shifting.
- R7: Each bit goes out on spi_mosi when its bit slot opens. spi_miso is captured at the SCLK edge in the middle of the slot. That edge is the leading edge when CPHA (config bit 1) is 0 and the trailing edge when CPHA is 1. Config bit 13 set sends and receives the least significant bit first; clear, the most significant bit goes first.
- R8: The engine shifts only while control bit 0 is 1. It stops with SCLK idle once the TX count (0x04C) and the RX count (0x034) both reach 0. Both count registers read back the words still remaining. When the last word finishes, status bit 0 (RX complete) and status bit 2 (TX complete) are set.
- R9: The engine may need a TX byte while the TX queue is empty. It then waits with SCLK idle, and carries on once software writes more bytes.
- R10: Status bits hold until cleared. Writing 1 to a status bit clears it.
- R11: Status bit 1 is set when the RX level reaches a threshold. Config bits 18:17 choose it: 0 means 8 entries, 1 means 4, and 2 or 3 means 1.
- R12: Bit 1 of the pin register (0x00C) drives spi_cs_n directly, from the cycle after the write. Writing 0 selects the device and writing 1 deselects it.
- R13: When the RX count is larger than the TX count, the extra words send 0x00 on MOSI. Their received bytes are still stored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | 12 | Register byte address |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_rd | input | 1 | Read strobe; a read of 0x020 pops the RX queue |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid the cycle after bus_rd |
| spi_sclk | output | 1 | Serial clock |
| spi_mosi | output | 1 | Serial data to the device |
| spi_miso | input | 1 | Serial data from the device |
| spi_cs_n | output | 1 | Chip select, held by software |

## Verification
The assertions check four things on every cycle:
- the divider never leaves its legal range;
- a flush empties the queue in the next cycle;
- an empty-queue read returns zero;
- the engine does not start a word while it still needs a TX byte and the queue is empty.

They also check that chip select copies the written pin bit. Other behaviours show only in the bench scenarios, which run the engine with an SPI loopback:
- the order of bits on MOSI in each of the four clock modes;
- the SCLK period;
- the automatic stop once both counts run out;
- zero-filled extra receive words;
- the threshold flag;
- resuming after a pause on an empty TX queue.

// File: rtl/spim_pkg.sv
package spim_pkg;
  localparam logic [11:0] ADR_CTL = 12'h000;
  localparam logic [11:0] ADR_CFG = 12'h004;
  localparam logic [11:0] ADR_STS = 12'h008;
  localparam logic [11:0] ADR_PIN = 12'h00C;
  localparam logic [11:0] ADR_TXD = 12'h010;
  localparam logic [11:0] ADR_RXD = 12'h020;
  localparam logic [11:0] ADR_DIV = 12'h030;
  localparam logic [11:0] ADR_RXN = 12'h034;
  localparam logic [11:0] ADR_TXN = 12'h04C;
  localparam logic [11:0] ADR_LVL = 12'h10C;

  typedef struct packed {
    logic       lsb;
    logic       cpol;
    logic       cpha;
    logic [1:0] thr_sel;
  } spim_cfg_t;

  // receive-level threshold chosen by the config select field
  function automatic logic [7:0] thr_entries(input logic [1:0] sel);
    case (sel)
      2'd0:    return 8'd8;
      2'd1:    return 8'd4;
      default: return 8'd1;
    endcase
  endfunction
endpackage

// File: rtl/spim_fifo.sv
module spim_fifo #(
  parameter int DEPTH = 16,
  parameter int WIDTH = 8,
  parameter int LVL_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             flush,
  input  logic             push,
  input  logic [WIDTH-1:0] din,
  input  logic             pop,
  output logic [WIDTH-1:0] dout,
  output logic [LVL_W-1:0] level,
  output logic             full,
  output logic             empty
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [WIDTH-1:0] mem [DEPTH];
  logic [PTR_W-1:0] wp, rp;
  logic             do_push, do_pop;

  function automatic logic [PTR_W-1:0] step(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign full    = (level == LVL_W'(DEPTH));
  assign empty   = (level == '0);
  assign do_push = push && !full;
  assign do_pop  = pop && !empty;
  assign dout    = mem[rp];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp    <= '0;
      rp    <= '0;
      level <= '0;
    end else if (flush) begin
      wp    <= '0;
      rp    <= '0;
      level <= '0;
    end else begin
      if (do_push) wp <= step(wp);
      if (do_pop)  rp <= step(rp);
      case ({do_push, do_pop})
        2'b10:   level <= level + 1'b1;
        2'b01:   level <= level - 1'b1;
        default: level <= level;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (do_push && !flush) mem[wp] <= din;
  end
endmodule

// File: rtl/spim_engine.sv
module spim_engine #(
  parameter int WORD_W = 8,
  parameter int DIV_W  = 11
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run,
  input  logic              cpol,
  input  logic              cpha,
  input  logic              lsb,
  input  logic [DIV_W-1:0]  div,
  input  logic              tx_need,
  input  logic              rx_need,
  input  logic              tx_empty,
  input  logic              rx_full,
  input  logic [WORD_W-1:0] tx_byte,
  output logic              tx_pop,
  output logic              word_end,
  output logic [WORD_W-1:0] rx_byte,
  output logic              busy,
  output logic              sclk,
  output logic              mosi,
  input  logic              miso
);
  localparam int BIT_W = $clog2(WORD_W);

  logic              half;
  logic [DIV_W-1:0]  hcnt;
  logic [DIV_W-1:0]  half_len;
  logic [BIT_W-1:0]  bitc;
  logic [WORD_W-1:0] sh_tx, sh_rx;
  logic              start, last_cyc, last_bit;

  assign start    = !busy && run && (tx_need || rx_need)
                    && (!tx_need || !tx_empty) && (!rx_need || !rx_full);
  assign tx_pop   = start && tx_need;
  assign half_len = half ? (div - (div >> 1)) : (div >> 1);
  assign last_cyc = (hcnt == half_len - 1'b1);
  assign last_bit = (bitc == BIT_W'(WORD_W - 1));
  assign word_end = run && busy && half && last_cyc && last_bit;
  assign rx_byte  = sh_rx;
  assign sclk     = busy ? (cpol ^ half ^ cpha) : cpol;
  assign mosi     = busy ? (lsb ? sh_tx[0] : sh_tx[WORD_W-1]) : 1'b0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy  <= 1'b0;
      half  <= 1'b0;
      hcnt  <= '0;
      bitc  <= '0;
      sh_tx <= '0;
      sh_rx <= '0;
    end else if (!run) begin
      busy <= 1'b0;
      half <= 1'b0;
      hcnt <= '0;
      bitc <= '0;
    end else if (start) begin
      busy  <= 1'b1;
      half  <= 1'b0;
      hcnt  <= '0;
      bitc  <= '0;
      sh_tx <= tx_need ? tx_byte : '0;
    end else if (busy) begin
      if (last_cyc) begin
        hcnt <= '0;
        half <= ~half;
        if (!half) begin
          // mid-slot edge: capture the incoming bit
          sh_rx <= lsb ? {miso, sh_rx[WORD_W-1:1]} : {sh_rx[WORD_W-2:0], miso};
        end else if (last_bit) begin
          busy <= 1'b0;
        end else begin
          bitc  <= bitc + 1'b1;
          sh_tx <= lsb ? (sh_tx >> 1) : (sh_tx << 1);
        end
      end else begin
        hcnt <= hcnt + 1'b1;
      end
    end
  end
endmodule

// File: rtl/spim_ctrl.sv
module spim_ctrl
  import spim_pkg::*;
#(
  parameter int FIFO_DEPTH = 16,
  parameter int WORD_W     = 8,
  parameter int CNT_W      = 16,
  parameter int DIV_W      = 11,
  parameter int DIV_RESET  = 4
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [11:0] bus_addr,
  input  logic        bus_wr,
  input  logic        bus_rd,
  input  logic [31:0] bus_wdata,
  output logic [31:0] bus_rdata,
  output logic        spi_sclk,
  output logic        spi_mosi,
  input  logic        spi_miso,
  output logic        spi_cs_n
);
  localparam int          LVL_W   = $clog2(FIFO_DEPTH + 1);
  localparam logic [31:0] DIV_MAX = (32'd1 << DIV_W) - 32'd1;

  logic             run_q, cs_q;
  spim_cfg_t        cfg_q;
  logic [2:0]       sts_q, sts_set, sts_clr;
  logic [DIV_W-1:0] div_q;
  logic [CNT_W-1:0] tx_rem, rx_rem;
  logic [31:0]      rd_val;

  logic wr_ctl, wr_cfg, wr_sts, wr_pin, wr_txd, wr_div, wr_rxn, wr_txn, rd_rxd;
  logic tx_flush, rx_flush, tx_need, rx_need;

  logic              tx_full, tx_empty, rx_full, rx_empty, tx_pop, rx_push;
  logic [LVL_W-1:0]  tx_lvl, rx_lvl;
  logic [WORD_W-1:0] tx_dout, rx_dout, eng_rx;
  logic              word_end, eng_busy;

  assign wr_ctl = bus_wr && (bus_addr == ADR_CTL);
  assign wr_cfg = bus_wr && (bus_addr == ADR_CFG);
  assign wr_sts = bus_wr && (bus_addr == ADR_STS);
  assign wr_pin = bus_wr && (bus_addr == ADR_PIN);
  assign wr_txd = bus_wr && (bus_addr == ADR_TXD);
  assign wr_div = bus_wr && (bus_addr == ADR_DIV);
  assign wr_rxn = bus_wr && (bus_addr == ADR_RXN);
  assign wr_txn = bus_wr && (bus_addr == ADR_TXN);
  assign rd_rxd = bus_rd && (bus_addr == ADR_RXD);

  assign tx_flush = wr_ctl && bus_wdata[2];
  assign rx_flush = wr_ctl && bus_wdata[3];
  assign tx_need  = (tx_rem != '0);
  assign rx_need  = (rx_rem != '0);
  assign rx_push  = word_end && rx_need;
  assign spi_cs_n = cs_q;

  spim_fifo #(.DEPTH(FIFO_DEPTH), .WIDTH(WORD_W), .LVL_W(LVL_W)) u_txq (
    .clk(clk), .rst_n(rst_n), .flush(tx_flush),
    .push(wr_txd), .din(bus_wdata[WORD_W-1:0]),
    .pop(tx_pop), .dout(tx_dout),
    .level(tx_lvl), .full(tx_full), .empty(tx_empty)
  );

  spim_fifo #(.DEPTH(FIFO_DEPTH), .WIDTH(WORD_W), .LVL_W(LVL_W)) u_rxq (
    .clk(clk), .rst_n(rst_n), .flush(rx_flush),
    .push(rx_push), .din(eng_rx),
    .pop(rd_rxd), .dout(rx_dout),
    .level(rx_lvl), .full(rx_full), .empty(rx_empty)
  );

  spim_engine #(.WORD_W(WORD_W), .DIV_W(DIV_W)) u_eng (
    .clk(clk), .rst_n(rst_n), .run(run_q),
    .cpol(cfg_q.cpol), .cpha(cfg_q.cpha), .lsb(cfg_q.lsb), .div(div_q),
    .tx_need(tx_need), .rx_need(rx_need),
    .tx_empty(tx_empty), .rx_full(rx_full), .tx_byte(tx_dout),
    .tx_pop(tx_pop), .word_end(word_end), .rx_byte(eng_rx),
    .busy(eng_busy), .sclk(spi_sclk), .mosi(spi_mosi), .miso(spi_miso)
  );

  // status: sets win over write-one-to-clear in the same cycle
  assign sts_set[0] = word_end && (rx_rem == CNT_W'(1));
  assign sts_set[1] = (8'(rx_lvl) >= thr_entries(cfg_q.thr_sel));
  assign sts_set[2] = word_end && (tx_rem == CNT_W'(1));
  assign sts_clr    = wr_sts ? bus_wdata[2:0] : 3'b000;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q  <= 1'b0;
      cs_q   <= 1'b1;
      cfg_q  <= '0;
      sts_q  <= '0;
      div_q  <= DIV_W'(DIV_RESET);
      tx_rem <= '0;
      rx_rem <= '0;
    end else begin
      if (wr_ctl) run_q <= bus_wdata[0];
      if (wr_pin) cs_q  <= bus_wdata[1];
      if (wr_cfg) begin
        cfg_q.cpha    <= bus_wdata[1];
        cfg_q.cpol    <= bus_wdata[2];
        cfg_q.lsb     <= bus_wdata[13];
        cfg_q.thr_sel <= bus_wdata[18:17];
      end
      if (wr_div) begin
        if (bus_wdata < 32'd2)          div_q <= DIV_W'(2);
        else if (bus_wdata > DIV_MAX)   div_q <= DIV_MAX[DIV_W-1:0];
        else                            div_q <= bus_wdata[DIV_W-1:0];
      end
      sts_q <= (sts_q & ~sts_clr) | sts_set;
      if (wr_txn)                     tx_rem <= bus_wdata[CNT_W-1:0];
      else if (word_end && tx_need)   tx_rem <= tx_rem - 1'b1;
      if (wr_rxn)                     rx_rem <= bus_wdata[CNT_W-1:0];
      else if (word_end && rx_need)   rx_rem <= rx_rem - 1'b1;
    end
  end

  always_comb begin
    rd_val = '0;
    case (bus_addr)
      ADR_CTL: rd_val[0] = run_q;
      ADR_CFG: begin
        rd_val[1]     = cfg_q.cpha;
        rd_val[2]     = cfg_q.cpol;
        rd_val[13]    = cfg_q.lsb;
        rd_val[18:17] = cfg_q.thr_sel;
      end
      ADR_STS: rd_val[2:0] = sts_q;
      ADR_PIN: rd_val[1]   = cs_q;
      ADR_RXD: rd_val      = rx_empty ? 32'd0 : 32'(rx_dout);
      ADR_DIV: rd_val      = 32'(div_q);
      ADR_RXN: rd_val      = 32'(rx_rem);
      ADR_TXN: rd_val      = 32'(tx_rem);
      ADR_LVL: begin
        rd_val[4]     = tx_full;
        rd_val[15:8]  = 8'(tx_lvl);
        rd_val[20]    = rx_empty;
        rd_val[31:24] = 8'(rx_lvl);
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      bus_rdata <= '0;
    else if (bus_rd) bus_rdata <= rd_val;
  end
endmodule

// File: rtl/spim_checker.sv
module spim_checker
  import spim_pkg::*;
#(
  parameter int FIFO_DEPTH = 16,
  parameter int DIV_W      = 11,
  parameter int LVL_W      = 5
) (
  input logic             clk,
  input logic             rst_n,
  input logic [11:0]      bus_addr,
  input logic             bus_wr,
  input logic             bus_rd,
  input logic [31:0]      bus_wdata,
  input logic [31:0]      bus_rdata,
  input logic             spi_cs_n,
  input logic             eng_busy,
  input logic             tx_need,
  input logic             tx_empty,
  input logic             rx_empty,
  input logic [LVL_W-1:0] tx_lvl,
  input logic             tx_flush,
  input logic [DIV_W-1:0] div_q
);
  AST_TX_LEVEL_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    tx_lvl <= LVL_W'(FIFO_DEPTH)); // R2

  AST_RX_EMPTY_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && bus_addr == ADR_RXD && rx_empty) |=> (bus_rdata == 32'd0)); // R3

  AST_TX_FLUSH_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    tx_flush |=> tx_empty); // R4

  AST_DIV_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
    (div_q >= DIV_W'(2))); // R5

  AST_PAUSE_NO_DATA: assert property (@(posedge clk) disable iff (!rst_n)
    (!eng_busy && tx_need && tx_empty) |=> !eng_busy); // R9

  AST_CS_FOLLOWS_PIN: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == ADR_PIN) |=> (spi_cs_n == $past(bus_wdata[1]))); // R12
endmodule

bind spim_ctrl spim_checker #(
  .FIFO_DEPTH(FIFO_DEPTH), .DIV_W(DIV_W), .LVL_W(LVL_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
  .bus_rd(bus_rd), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
  .spi_cs_n(spi_cs_n), .eng_busy(eng_busy), .tx_need(tx_need),
  .tx_empty(tx_empty), .rx_empty(rx_empty), .tx_lvl(tx_lvl),
  .tx_flush(tx_flush), .div_q(div_q)
);

// File: tb/tb_spim_ctrl.sv
module tb_spim_ctrl;
  localparam logic [11:0] A_CTL = 12'h000, A_CFG = 12'h004, A_STS = 12'h008,
                          A_PIN = 12'h00C, A_TXD = 12'h010, A_RXD = 12'h020,
                          A_DIV = 12'h030, A_RXN = 12'h034, A_TXN = 12'h04C,
                          A_LVL = 12'h10C;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [11:0] bus_addr = '0;
  logic        bus_wr = 1'b0, bus_rd = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        spi_sclk, spi_mosi, spi_miso, spi_cs_n;
  logic        lb_inv = 1'b0;
  logic        m_cpol = 1'b0, m_cpha = 1'b0;

  int n_chk = 0, n_fail = 0;
  logic timed_out = 1'b0;

  always #4 clk = ~clk; // 125 MHz

  assign spi_miso = spi_mosi ^ lb_inv;

  spim_ctrl dut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_rd(bus_rd), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .spi_sclk(spi_sclk), .spi_mosi(spi_mosi), .spi_miso(spi_miso),
    .spi_cs_n(spi_cs_n)
  );

  // line monitor: free-running counters, sampled as differences by tasks
  int       cyc = 0;
  int       tog_total = 0;
  int       samp_prev = 0, samp_last = 0;
  logic [7:0] mon_bits = '0;
  logic     prev_sclk = 1'b0;

  always @(posedge clk) cyc++;

  always @(negedge clk) begin
    if (spi_sclk !== prev_sclk) begin
      tog_total++;
      if (spi_sclk == (m_cpol ^ ~m_cpha)) begin
        mon_bits  = {mon_bits[6:0], spi_mosi};
        samp_prev = samp_last;
        samp_last = cyc;
      end
    end
    prev_sclk = spi_sclk;
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [11:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_rd = 1'b1;
    @(negedge clk);
    bus_rd = 1'b0;
    d = bus_rdata;
  endtask

  task automatic wait_done(input int limit);
    logic [31:0] s;
    for (int i = 0; i < limit; i++) begin
      rd(A_STS, s);
      if ((s & 32'h5) == 32'h5) break;
    end
  endtask

  function automatic logic [7:0] rev8(input logic [7:0] b);
    logic [7:0] r;
    for (int i = 0; i < 8; i++) r[i] = b[7-i];
    return r;
  endfunction

  task automatic t_reset();
    logic [31:0] v;
    check("R1 cs_n", 32'(spi_cs_n), 32'd1);
    check("R1 sclk", 32'(spi_sclk), 32'd0);
    rd(A_DIV, v); check("R1 div", v, 32'd4);
    rd(A_STS, v); check("R1 status", v, 32'd0);
    rd(A_LVL, v); check("R1 levels", v, 32'h0010_0000);
  endtask

  task automatic t_fill_flush();
    logic [31:0] v;
    for (int i = 0; i < 17; i++) wr(A_TXD, 32'(i));
    rd(A_LVL, v); check("R2 full level, 17th write dropped", v, 32'h0010_1010);
    wr(A_CTL, 32'h4);
    rd(A_LVL, v); check("R4 tx flush", v, 32'h0010_0000);
  endtask

  task automatic t_div();
    logic [31:0] v;
    wr(A_DIV, 32'd1);      rd(A_DIV, v); check("R5 clamp low", v, 32'd2);
    wr(A_DIV, 32'hFFFF);   rd(A_DIV, v); check("R5 clamp high", v, 32'h7FF);
    wr(A_DIV, 32'd6);      rd(A_DIV, v); check("R5 in range", v, 32'd6);
  endtask

  task automatic t_cs();
    wr(A_PIN, 32'h0); check("R12 cs asserted", 32'(spi_cs_n), 32'd0);
    wr(A_PIN, 32'h2); check("R12 cs released", 32'(spi_cs_n), 32'd1);
  endtask

  task automatic t_xfer(input logic cpol, input logic cpha, input logic lsb,
                        input logic inv, input logic [7:0] b);
    logic [31:0] v;
    int tog0;
    wr(A_CTL, 32'hC);
    wr(A_STS, 32'h7);
    wr(A_CFG, (32'(lsb) << 13) | (32'(cpol) << 2) | (32'(cpha) << 1) | (32'd2 << 17));
    wr(A_DIV, 32'd6);
    wr(A_TXN, 32'd1);
    wr(A_RXN, 32'd1);
    wr(A_TXD, 32'(b));
    m_cpol = cpol; m_cpha = cpha; lb_inv = inv;
    check("R6 idle level before run", 32'(spi_sclk), 32'(cpol));
    tog0 = tog_total;
    wr(A_CTL, 32'h1);
    wait_done(200);
    check("R7 mosi bit order", 32'(mon_bits), 32'(lsb ? rev8(b) : b));
    check("R6 sclk period", 32'(samp_last - samp_prev), 32'd6);
    check("R6 idle level after word", 32'(spi_sclk), 32'(cpol));
    check("R8 one word of edges", 32'(tog_total - tog0), 32'd16);
    rd(A_TXN, v); check("R8 tx count drained", v, 32'd0);
    rd(A_RXN, v); check("R8 rx count drained", v, 32'd0);
    rd(A_STS, v); check("R8 R11 status after word", v, 32'h7);
    rd(A_RXD, v); check("R7 loopback byte", v, 32'(b ^ {8{inv}}));
    wr(A_CTL, 32'h0);
    wr(A_STS, 32'h7);
    rd(A_STS, v); check("R10 status cleared", v, 32'd0);
  endtask

  task automatic t_pause();
    logic [31:0] v;
    int tog0;
    wr(A_CTL, 32'hC);
    wr(A_CFG, 32'h0);
    wr(A_DIV, 32'd4);
    wr(A_STS, 32'h7);
    wr(A_TXN, 32'd3);
    wr(A_RXN, 32'd3);
    wr(A_TXD, 32'h3C);
    m_cpol = 1'b0; m_cpha = 1'b0; lb_inv = 1'b0;
    tog0 = tog_total;
    wr(A_CTL, 32'h1);
    repeat (200) @(negedge clk);
    check("R9 paused after one word", 32'(tog_total - tog0), 32'd16);
    check("R9 sclk idle in pause", 32'(spi_sclk), 32'd0);
    rd(A_LVL, v); check("R9 one byte received", v, 32'h0100_0000);
    rd(A_TXN, v); check("R8 tx words left", v, 32'd2);
    wr(A_TXD, 32'h5A);
    wr(A_TXD, 32'hC3);
    wait_done(200);
    check("R9 resumed", 32'(tog_total - tog0), 32'd48);
    rd(A_STS, v); check("R11 below threshold of 8", v, 32'h5);
    rd(A_RXD, v); check("R3 order 1", v, 32'h3C);
    rd(A_RXD, v); check("R3 order 2", v, 32'h5A);
    rd(A_RXD, v); check("R3 order 3", v, 32'hC3);
    rd(A_RXD, v); check("R3 empty read", v, 32'h0);
    wr(A_CTL, 32'h0);
  endtask

  task automatic t_rx_longer();
    logic [31:0] v;
    wr(A_CTL, 32'hC);
    wr(A_CFG, 32'h0);
    wr(A_STS, 32'h7);
    wr(A_TXN, 32'd1);
    wr(A_RXN, 32'd3);
    wr(A_TXD, 32'hA5);
    m_cpol = 1'b0; m_cpha = 1'b0; lb_inv = 1'b0;
    wr(A_CTL, 32'h1);
    wait_done(300);
    rd(A_LVL, v); check("R13 three bytes stored", v, 32'h0300_0000);
    rd(A_RXD, v); check("R13 first word", v, 32'hA5);
    rd(A_RXD, v); check("R13 zero fill 1", v, 32'h00);
    rd(A_RXD, v); check("R13 zero fill 2", v, 32'h00);
    wr(A_CTL, 32'h8);
    rd(A_LVL, v); check("R4 rx flush", v, 32'h0010_0000);
  endtask

  task automatic run_all();
    t_reset();
    t_fill_flush();
    t_div();
    t_cs();
    t_xfer(1'b0, 1'b0, 1'b0, 1'b0, 8'hB4);
    t_xfer(1'b0, 1'b1, 1'b1, 1'b1, 8'h1E);
    t_xfer(1'b1, 1'b0, 1'b1, 1'b0, 8'h96);
    t_xfer(1'b1, 1'b1, 1'b0, 1'b1, 8'h6D);
    t_pause();
    t_rx_longer();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    fork
      run_all();
      begin
        repeat (150000) @(posedge clk);
        timed_out = 1'b1;
      end
    join_any
    disable fork;
    if (timed_out) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=timeout expected=completion");
    end
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule